// File: doc/BRIEF.md
# Multi-Mode Event Timer Counter

A 16-bit timer channel that counts events from one of two primary sources: an internal tick running at half the system clock rate, or an external pin. A three-bit mode field picks how events are turned into counts. The options are single-edge counting, counting both edges, counting only while a secondary pin is high (which measures that pulse's width), two-phase quadrature decoding, and up/down counting steered by the level of the secondary pin. Both external pins pass through a two-flop synchronizer. Edges are detected on the synchronized levels in the system clock domain.

Each count event is compared against a programmable compare value. When an event arrives while the count equals that value, the channel raises a match. On a match it either loads a programmable reload value or, when count-through is selected, keeps counting and wraps past all ones to zero. A sticky match flag records each match, and writing 1 clears it. In one-shot operation the channel writes mode 000 into its own mode field at the match and stops.

Top module: `evt_timer`

## Requirements
- R1: After reset the count is 0, the match flag is 0, the mode read-back is 000, the configuration error output is 0, the compare value is 0xFFFF and the reload value is 0.
- R2: In mode 000, and in the unused encodings 110 and 111, the count holds its value whatever the pins do.
- R3: Mode 001 adds 1 per rising edge of the primary source, or per falling edge when the polarity bit is 1. The internal source (source-select 0) gives exactly one event in every two system clock cycles.
- R4: Mode 010 with the external source (source-select 1) adds 1 on every rising and every falling edge of the primary pin. Mode 010 with the internal source drives the configuration error output to 1 and does not count.
- R5: Mode 011 counts primary-source events only while the synchronized secondary pin is 1. With the internal source, a secondary pulse N cycles long (N even) yields N/2 counts.
- R6: Mode 100 decodes phase A (primary pin) and phase B (secondary pin). It counts up on the AB sequence 00,10,11,01,00 and down on the reverse sequence. A step where both phases change at once is ignored.
- R7: Mode 101 adds 1 per active primary edge while the secondary pin is 0, and subtracts 1 per active primary edge while the secondary pin is 1.
- R8: An event that arrives while the count equals the compare value loads the reload value instead of stepping, and sets the match flag.
- R9: With count-through set, an event at the compare value steps normally and still sets the flag. Counting up from 0xFFFF wraps to 0.
- R10: With one-shot set, the match writes 000 into the mode field, and later events leave the count unchanged.
- R11: The match flag stays set until a write-1 clear. A match and a clear in the same cycle leave the flag set.
- R12: A count write loads the written value. A count write in the same cycle as a count event takes precedence, and that event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_mode_i | input | 3 | Count mode to write |
| ctl_ext_i | input | 1 | Primary source: 1 external pin, 0 internal half-rate tick |
| ctl_pol_i | input | 1 | Polarity: 1 counts falling edges |
| ctl_once_i | input | 1 | One-shot operation |
| ctl_thru_i | input | 1 | Count-through at compare |
| cmp_we_i | input | 1 | Compare value write strobe |
| rld_we_i | input | 1 | Reload value write strobe |
| cnt_we_i | input | 1 | Count write strobe |
| wdata_i | input | 16 | Write data for compare, reload and count |
| flag_clr_i | input | 1 | Write-1 clear of the match flag |
| pri_i | input | 1 | Primary pin (phase A) |
| sec_i | input | 1 | Secondary pin (gate, direction or phase B) |
| cnt_o | output | 16 | Current count |
| flag_o | output | 1 | Sticky match flag |
| mode_o | output | 3 | Mode field read-back |
| cfg_err_o | output | 1 | Illegal dual-edge configuration |

## Verification
Two pairs of functions can act in the same cycle. A compare match can coincide with a software clear of the flag, and a count event can coincide with a software write of the count. To provoke each collision, the bench toggles the primary pin and asserts the strobe exactly two cycles later, which is the cycle in which the synchronized edge reaches the counter. The expected results are a flag that stays set, and a count that equals the written value with no extra step afterwards.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_EDGE = 3'd1,
    MODE_DUAL = 3'd2,
    MODE_GATE = 3'd3,
    MODE_QUAD = 3'd4,
    MODE_DIR  = 3'd5,
    MODE_RSV6 = 3'd6,
    MODE_RSV7 = 3'd7
  } mode_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/evt_decode.sv
module evt_decode
  import evt_timer_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  ext_i,
  input  logic  pol_i,
  input  logic  pri_i,
  input  logic  sec_i,
  output logic  up_o,
  output logic  dn_o,
  output logic  err_o
);
  logic div_q, p_prev_q, a_prev_q, b_prev_q;
  logic p_now, rise, fall, act, any_e;
  logic a_chg, b_chg, q_step, q_up;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= 1'b0;
      p_prev_q <= 1'b0;
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
    end else begin
      div_q    <= ~div_q;
      p_prev_q <= p_now;
      a_prev_q <= pri_i;
      b_prev_q <= sec_i;
    end
  end

  assign p_now  = ext_i ? pri_i : div_q;
  assign rise   = p_now & ~p_prev_q;
  assign fall   = ~p_now & p_prev_q;
  assign act    = pol_i ? fall : rise;
  assign any_e  = rise | fall;
  assign a_chg  = pri_i ^ a_prev_q;
  assign b_chg  = sec_i ^ b_prev_q;
  assign q_step = a_chg ^ b_chg;     // simultaneous change is dropped
  assign q_up   = pri_i ^ b_prev_q;
  assign err_o  = (mode_i == MODE_DUAL) && !ext_i;

  always_comb begin
    up_o = 1'b0;
    dn_o = 1'b0;
    unique case (mode_i)
      MODE_EDGE: up_o = act;
      MODE_DUAL: up_o = any_e & ext_i;
      MODE_GATE: up_o = act & sec_i;
      MODE_QUAD: begin
        up_o = q_step & q_up;
        dn_o = q_step & ~q_up;
      end
      MODE_DIR: begin
        up_o = act & ~sec_i;
        dn_o = act & sec_i;
      end
      default: ;
    endcase
  end

  assert_no_dual_internal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !up_o && !dn_o);
  assert_one_dir_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));
endmodule

// File: rtl/evt_core.sv
module evt_core #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] rld_i,
  input  logic         thru_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign hit_o = (up_i | dn_i) && (cnt_q == cmp_i);

  always_comb begin
    cnt_d = cnt_q;
    if (we_i)                cnt_d = wdata_i;
    else if (hit_o && !thru_i) cnt_d = rld_i;
    else if (up_i)           cnt_d = cnt_q + 1'b1;
    else if (dn_i)           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !thru_i && !we_i |=> cnt_q == $past(rld_i));
  assert_write_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cnt_q == $past(wdata_i));
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_i && !dn_i && !we_i |=> $stable(cnt_q));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctl_we_i,
  input  logic [2:0]   ctl_mode_i,
  input  logic         ctl_ext_i,
  input  logic         ctl_pol_i,
  input  logic         ctl_once_i,
  input  logic         ctl_thru_i,
  input  logic         cmp_we_i,
  input  logic         rld_we_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         flag_clr_i,
  input  logic         pri_i,
  input  logic         sec_i,
  output logic [W-1:0] cnt_o,
  output logic         flag_o,
  output logic [2:0]   mode_o,
  output logic         cfg_err_o
);
  mode_e        mode_q;
  logic         ext_q, pol_q, once_q, thru_q, flag_q;
  logic [W-1:0] cmp_q, rld_q;
  logic [1:0]   pins_s;
  logic         up, dn, hit;

  evt_sync #(.W(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({sec_i, pri_i}), .q_o(pins_s)
  );

  evt_decode u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_q), .ext_i(ext_q),
    .pol_i(pol_q), .pri_i(pins_s[0]), .sec_i(pins_s[1]),
    .up_o(up), .dn_o(dn), .err_o(cfg_err_o)
  );

  evt_core #(.W(W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .up_i(up), .dn_i(dn),
    .we_i(cnt_we_i), .wdata_i(wdata_i), .cmp_i(cmp_q), .rld_i(rld_q),
    .thru_i(thru_q), .cnt_o(cnt_o), .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      ext_q  <= 1'b0;
      pol_q  <= 1'b0;
      once_q <= 1'b0;
      thru_q <= 1'b0;
      cmp_q  <= '1;
      rld_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctl_we_i) begin
        mode_q <= mode_e'(ctl_mode_i);
        ext_q  <= ctl_ext_i;
        pol_q  <= ctl_pol_i;
        once_q <= ctl_once_i;
        thru_q <= ctl_thru_i;
      end else if (hit && once_q) begin
        mode_q <= MODE_OFF;   // one-shot self-disable
      end
      if (cmp_we_i) cmp_q <= wdata_i;
      if (rld_we_i) rld_q <= wdata_i;
      if (hit)             flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign mode_o = mode_q;

  assert_flag_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_q);
  assert_oneshot_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && once_q && !ctl_we_i |=> mode_q == MODE_OFF);
  assert_flag_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !flag_clr_i |=> flag_q);
endmodule

// File: tb/tb_evt_timer.sv
`timescale 1ns/1ps
module tb_evt_timer;
  logic        clk = 0, rst_ni = 0;
  logic        ctl_we = 0, ctl_ext = 0, ctl_pol = 0, ctl_once = 0, ctl_thru = 0;
  logic [2:0]  ctl_mode = 0;
  logic        cmp_we = 0, rld_we = 0, cnt_we = 0, flag_clr = 0, pri = 0, sec = 0;
  logic [15:0] wdata = 0;
  logic [15:0] cnt;
  logic        flag, cfg_err;
  logic [2:0]  mode;
  int          errors = 0, checks = 0;
  logic [15:0] v0;

  always #2.5 clk = ~clk;

  evt_timer dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctl_we_i(ctl_we), .ctl_mode_i(ctl_mode),
    .ctl_ext_i(ctl_ext), .ctl_pol_i(ctl_pol), .ctl_once_i(ctl_once),
    .ctl_thru_i(ctl_thru), .cmp_we_i(cmp_we), .rld_we_i(rld_we),
    .cnt_we_i(cnt_we), .wdata_i(wdata), .flag_clr_i(flag_clr),
    .pri_i(pri), .sec_i(sec), .cnt_o(cnt), .flag_o(flag), .mode_o(mode),
    .cfg_err_o(cfg_err)
  );

  // {phase A, phase B, expected count}
  localparam logic [17:0] QV [8] = '{
    {2'b10, 16'd1}, {2'b11, 16'd2}, {2'b01, 16'd3}, {2'b00, 16'd4},
    {2'b01, 16'd3}, {2'b11, 16'd2}, {2'b00, 16'd2}, {2'b10, 16'd3}
  };

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [2:0] m, input logic e, input logic p,
                         input logic o, input logic t);
    ctl_we = 1; ctl_mode = m; ctl_ext = e; ctl_pol = p; ctl_once = o; ctl_thru = t;
    cyc(1);
    ctl_we = 0;
    cyc(3);
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    cnt_we = 1; wdata = v; cyc(1); cnt_we = 0;
  endtask
  task automatic wr_cmp(input logic [15:0] v);
    cmp_we = 1; wdata = v; cyc(1); cmp_we = 0;
  endtask
  task automatic wr_rld(input logic [15:0] v);
    rld_we = 1; wdata = v; cyc(1); rld_we = 0;
  endtask
  task automatic clr_flag();
    flag_clr = 1; cyc(1); flag_clr = 0;
  endtask
  task automatic tog_pri();
    pri = ~pri; cyc(4);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    check("R1 cnt", cnt, 0); check("R1 flag", flag, 0);
    check("R1 mode", mode, 0); check("R1 err", cfg_err, 0);
    rst_ni = 1; cyc(2);

    // R2 disabled and reserved modes hold
    set_ctl(3'd0, 1, 0, 0, 0); wr_cnt(16'h0040);
    tog_pri(); tog_pri();
    check("R2 mode000 hold", cnt, 16'h0040);
    set_ctl(3'd6, 1, 0, 0, 0); wr_cnt(16'h0041);
    tog_pri(); tog_pri();
    check("R2 mode110 hold", cnt, 16'h0041);

    // R3 rising edges external
    set_ctl(3'd1, 1, 0, 0, 0); wr_cnt(0);
    tog_pri(); check("R3 rise", cnt, 1);
    tog_pri(); check("R3 fall ignored", cnt, 1);
    set_ctl(3'd1, 1, 1, 0, 0); wr_cnt(0);
    tog_pri(); check("R3 pol rise ignored", cnt, 0);
    tog_pri(); check("R3 pol fall", cnt, 1);
    // R3 internal half-rate tick
    set_ctl(3'd1, 0, 0, 0, 0);
    v0 = cnt; cyc(20);
    check("R3 internal rate", cnt - v0, 10);

    // R4 dual edge
    set_ctl(3'd2, 1, 0, 0, 0); wr_cnt(0);
    tog_pri(); tog_pri();
    check("R4 dual ext", cnt, 2);
    set_ctl(3'd2, 0, 0, 0, 0); wr_cnt(5);
    cyc(10);
    check("R4 dual internal no count", cnt, 5);
    check("R4 err flag", cfg_err, 1);

    // R5 gated width
    sec = 0;
    set_ctl(3'd3, 0, 0, 0, 0); wr_cnt(0); cyc(4);
    check("R5 gate closed", cnt, 0);
    sec = 1; cyc(20); sec = 0; cyc(6);
    check("R5 gated width", cnt, 10);

    // R6 quadrature table
    pri = 0; sec = 0; cyc(4);
    set_ctl(3'd4, 1, 0, 0, 0); wr_cnt(0);
    for (int i = 0; i < 8; i++) begin
      pri = QV[i][17]; sec = QV[i][16]; cyc(4);
      check($sformatf("R6 quad step %0d", i), cnt, QV[i][15:0]);
    end
    pri = 0; sec = 0; cyc(4);

    // R7 count with direction
    set_ctl(3'd5, 1, 0, 0, 0); wr_cnt(10);
    tog_pri(); tog_pri(); tog_pri(); tog_pri();
    check("R7 up", cnt, 12);
    sec = 1; cyc(4);
    tog_pri(); tog_pri();
    check("R7 down", cnt, 11);
    sec = 0; cyc(4);

    // R8 reload at compare
    set_ctl(3'd1, 1, 0, 0, 0);
    wr_cmp(5); wr_rld(2); wr_cnt(4); clr_flag();
    tog_pri(); tog_pri(); check("R8 reach cmp", cnt, 5);
    check("R8 no flag before", flag, 0);
    tog_pri(); tog_pri(); check("R8 reload", cnt, 2);
    check("R8 flag", flag, 1);

    // R9 count-through and wrap
    set_ctl(3'd1, 1, 0, 0, 1); clr_flag(); wr_cnt(5);
    tog_pri(); tog_pri(); check("R9 through", cnt, 6);
    check("R9 flag", flag, 1);
    wr_cmp(16'h0010); wr_cnt(16'hFFFE);
    tog_pri(); tog_pri(); tog_pri(); tog_pri();
    check("R9 wrap", cnt, 0);

    // R10 one-shot
    set_ctl(3'd1, 1, 0, 1, 0); wr_cmp(3); wr_rld(0); wr_cnt(2); clr_flag();
    tog_pri(); tog_pri(); check("R10 at cmp", cnt, 3);
    tog_pri(); tog_pri(); check("R10 reload", cnt, 0);
    check("R10 mode cleared", mode, 0);
    tog_pri(); tog_pri(); check("R10 stopped", cnt, 0);

    // R11 flag set vs clear collision
    set_ctl(3'd1, 1, 0, 0, 0); wr_cmp(7); wr_rld(1); wr_cnt(7); clr_flag();
    check("R11 cleared", flag, 0);
    pri = 1; cyc(2); flag_clr = 1; cyc(1); flag_clr = 0;
    check("R11 set wins", flag, 1);
    check("R11 reload on hit", cnt, 1);
    pri = 0; cyc(4);
    check("R11 sticky", flag, 1);
    clr_flag(); check("R11 w1c", flag, 0);

    // R12 count write vs event
    wr_cmp(16'hFFFF); wr_cnt(3);
    pri = 1; cyc(2); cnt_we = 1; wdata = 16'h0100; cyc(1); cnt_we = 0;
    cyc(3);
    check("R12 write wins", cnt, 16'h0100);
    pri = 0; cyc(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule